// File: doc/BRIEF.md
# Extended Multiply and Divide Unit

A multi-cycle arithmetic unit that sits beside the register file of a 16-bit core and carries out the wide multiply and divide operations. It takes the three working registers D, X and Y plus the current condition flags, runs one of four operations picked by `op_i`, and hands back new D, X and Y values and new flags. The core writes the returned values back whole: a register or flag that the operation leaves alone comes back equal to its input.

Division is a shift-and-subtract loop over unsigned magnitudes, one quotient bit per clock, with sign handling before and after the loop. The multiply is a shift-add loop over magnitudes. A request is made by raising `start_i` while `busy_o` is low. `done_o` then pulses for one cycle with the results, which stay on the outputs until the next `done_o` pulse.

Top module: `ext_muldiv`

## Requirements
- R1: After reset `busy_o`, `done_o`, `d_o`, `x_o`, `y_o` and `flags_o` are all zero. The flag vector packs C in bit 0, V in bit 1, Z in bit 2 and N in bit 3, on `flags_i` and on `flags_o`.
- R2: With op 0 (signed 16/16 divide), D is divided by X, both as two's complement. The quotient is truncated toward zero and returned in X. The remainder takes the sign of the dividend and is returned in D. Y is returned unchanged.
- R3: With op 1 (unsigned 32/16 divide), the 32-bit value {Y,D} is divided by X. The low 16 bits of the quotient go to Y, the remainder goes to D, and X is returned unchanged.
- R4: With op 2 (signed 32/16 divide), {Y,D} and X are treated as two's complement. The register mapping is the same as for R3, with truncating division and a remainder that takes the sign of the dividend.
- R5: For any divide with X equal to zero, C is set and D, X, Y, V, Z and N are returned equal to their inputs.
- R6: For any divide with a nonzero divisor, C is cleared and Z is set exactly when the full quotient is zero. N is bit 15 of the returned quotient. V is set when the quotient exceeds 16 bits for op 1, or when it lies outside -32768..32767 for ops 0 and 2.
- R7: With op 3 (signed multiply), D and Y are multiplied as signed 16-bit values. The high half of the 32-bit product goes to Y, the low half to D, and X is returned unchanged.
- R8: For the multiply, Z is set when the product is zero, N is product bit 31, C is product bit 15, and V is returned equal to its input.
- R9: A start is accepted only while `busy_o` is low. `busy_o` is high in the cycle after an accepted start. A start raised while busy is ignored and does not change the result of the operation in progress.
- R10: `done_o` is high for exactly one cycle. Counting the accepting clock edge as edge 1, it rises at edge 19 for ops 0 and 3 and at edge 35 for ops 1 and 2. `busy_o` is low in the `done_o` cycle.
- R11: `d_o`, `x_o`, `y_o` and `flags_o` change only on the edge that raises `done_o`, and hold their values between pulses whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an operation |
| op_i | input | 2 | 0 signed 16/16 div, 1 unsigned 32/16 div, 2 signed 32/16 div, 3 signed multiply |
| d_i | input | 16 | D register in |
| x_i | input | 16 | X register in |
| y_i | input | 16 | Y register in |
| flags_i | input | 4 | Flags in {N,Z,V,C} |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| d_o | output | 16 | D register out |
| x_o | output | 16 | X register out |
| y_o | output | 16 | Y register out |
| flags_o | output | 4 | Flags out {N,Z,V,C} |

## Verification
The bench crosses the signed extremes 0x8000, 0x7FFF, -1, 0 and 1 on every operand of every operation, then adds pseudo-random operands and a set of directed cases. A design with a wrong sign fixup would give a remainder with the divisor's sign, or a misplaced magnitude for -32768. The directed cases are -32768/-1, -2^31/-1, and a 32/16 divide where Y is just below or equal to X. These land on the V boundary, and a range check that is off by one at either end reports overflow wrongly. Zero divisors check that no register or flag other than C is written. A start raised mid-operation, and inputs changed after `done_o`, expose a unit that recaptures its operands or lets its outputs follow the inputs.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    OP_SDIV16 = 2'd0,
    OP_UDIV32 = 2'd1,
    OP_SDIV32 = 2'd2,
    OP_SMUL   = 2'd3
  } mdu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_RUN,
    ST_FIN
  } mdu_state_e;

  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;
endpackage

// File: rtl/mdu_operand_prep.sv
module mdu_operand_prep import mdu_pkg::*; #(
  parameter int DW = 16,
  localparam int QW = 2 * DW
) (
  input  mdu_op_e         op_i,
  input  logic [DW-1:0]   d_i,
  input  logic [DW-1:0]   x_i,
  input  logic [DW-1:0]   y_i,
  output logic [QW-1:0]   dvd_o,
  output logic [DW-1:0]   dvs_o,
  output logic [DW-1:0]   mca_o,
  output logic [DW-1:0]   mcb_o,
  output logic            q_neg_o,
  output logic            r_neg_o,
  output logic            p_neg_o,
  output logic            dvs_zero_o,
  output logic            long_o
);
  logic [DW-1:0] d_abs, x_abs, y_abs;
  logic [QW-1:0] wide, wide_abs;

  always_comb begin
    d_abs    = d_i[DW-1] ? -d_i : d_i;
    x_abs    = x_i[DW-1] ? -x_i : x_i;
    y_abs    = y_i[DW-1] ? -y_i : y_i;
    wide     = {y_i, d_i};
    wide_abs = y_i[DW-1] ? -wide : wide;

    mca_o      = d_abs;
    mcb_o      = y_abs;
    p_neg_o    = d_i[DW-1] ^ y_i[DW-1];
    dvs_zero_o = (x_i == '0);
    dvd_o      = '0;
    dvs_o      = x_abs;
    q_neg_o    = 1'b0;
    r_neg_o    = 1'b0;
    long_o     = 1'b0;
    unique case (op_i)
      OP_SDIV16: begin
        // left-aligned so 16 steps leave the quotient in the low half
        dvd_o   = {d_abs, {DW{1'b0}}};
        q_neg_o = d_i[DW-1] ^ x_i[DW-1];
        r_neg_o = d_i[DW-1];
      end
      OP_UDIV32: begin
        dvd_o  = wide;
        dvs_o  = x_i;
        long_o = 1'b1;
      end
      OP_SDIV32: begin
        dvd_o   = wide_abs;
        q_neg_o = y_i[DW-1] ^ x_i[DW-1];
        r_neg_o = y_i[DW-1];
        long_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
  parameter int DW = 16,
  localparam int QW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [QW-1:0] dvd_i,
  input  logic [DW-1:0] dvs_i,
  output logic [QW-1:0] quo_o,
  output logic [DW-1:0] rem_o
);
  logic [DW-1:0] rem_q, dvs_q;
  logic [QW-1:0] quo_q;
  logic [DW:0]   shifted;
  logic [DW+1:0] diff;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[QW-1]};
    diff    = {1'b0, shifted} - {2'b00, dvs_q};
    fits    = ~diff[DW+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      dvs_q <= dvs_i;
      quo_q <= dvd_i;
    end else if (step_i) begin
      rem_q <= fits ? diff[DW-1:0] : shifted[DW-1:0];
      quo_q <= {quo_q[QW-2:0], fits};
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
  parameter int DW = 16,
  localparam int QW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [QW-1:0] prod_o
);
  logic [QW-1:0] acc_q, mcand_q;
  logic [DW-1:0] mplier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (load_i) begin
      acc_q    <= '0;
      mcand_q  <= {{DW{1'b0}}, a_i};
      mplier_q <= b_i;
    end else if (step_i) begin
      if (mplier_q[0]) acc_q <= acc_q + mcand_q;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
    end
  end

  assign prod_o = acc_q;
endmodule

// File: rtl/mdu_result_fix.sv
module mdu_result_fix import mdu_pkg::*; #(
  parameter int DW = 16,
  localparam int QW = 2 * DW
) (
  input  mdu_op_e       op_i,
  input  logic [QW-1:0] quo_i,
  input  logic [DW-1:0] rem_i,
  input  logic [QW-1:0] prod_i,
  input  logic          q_neg_i,
  input  logic          r_neg_i,
  input  logic          p_neg_i,
  input  logic          dvs_zero_i,
  input  logic [DW-1:0] d_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic [3:0]    flags_i,
  output logic [DW-1:0] d_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o,
  output logic [3:0]    flags_o
);
  localparam logic [QW-1:0] NEG_LIM = QW'(1) << (DW - 1);
  localparam logic [QW-1:0] POS_LIM = NEG_LIM - QW'(1);

  logic [QW-1:0] q_mag, q_s, p_s;
  logic [DW-1:0] r_s;
  logic          ovf;

  always_comb begin
    q_mag = (op_i == OP_SDIV16) ? {{DW{1'b0}}, quo_i[DW-1:0]} : quo_i;
    q_s   = q_neg_i ? -q_mag : q_mag;
    r_s   = r_neg_i ? -rem_i : rem_i;
    p_s   = p_neg_i ? -prod_i : prod_i;
    if (op_i == OP_UDIV32) ovf = |quo_i[QW-1:DW];
    else                   ovf = q_neg_i ? (q_mag > NEG_LIM) : (q_mag > POS_LIM);

    d_o     = d_i;
    x_o     = x_i;
    y_o     = y_i;
    flags_o = flags_i;
    if (op_i == OP_SMUL) begin
      y_o            = p_s[QW-1:DW];
      d_o            = p_s[DW-1:0];
      flags_o[FLG_Z] = (p_s == '0);
      flags_o[FLG_N] = p_s[QW-1];
      flags_o[FLG_C] = p_s[DW-1];
    end else if (dvs_zero_i) begin
      flags_o[FLG_C] = 1'b1;
    end else begin
      d_o = r_s;
      if (op_i == OP_SDIV16) x_o = q_s[DW-1:0];
      else                   y_o = q_s[DW-1:0];
      flags_o[FLG_C] = 1'b0;
      flags_o[FLG_V] = ovf;
      flags_o[FLG_Z] = (q_mag == '0);
      flags_o[FLG_N] = q_s[DW-1];
    end
  end
endmodule

// File: rtl/ext_muldiv.sv
module ext_muldiv import mdu_pkg::*; #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] d_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic [3:0]    flags_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] d_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o,
  output logic [3:0]    flags_o
);
  localparam int QW = 2 * DW;
  localparam int CW = $clog2(QW + 1);

  mdu_state_e    state_q;
  logic [CW-1:0] cnt_q;
  mdu_op_e       op_q;
  logic [DW-1:0] d_q, x_q, y_q;
  logic [3:0]    flags_q;
  logic          done_q;

  logic [QW-1:0] dvd, quo, prod;
  logic [DW-1:0] dvs, mca, mcb, rem;
  logic          q_neg, r_neg, p_neg, dvs_zero, long_op;
  logic [DW-1:0] d_fix, x_fix, y_fix;
  logic [3:0]    flags_fix;

  mdu_operand_prep #(.DW(DW)) u_prep (
    .op_i(op_q), .d_i(d_q), .x_i(x_q), .y_i(y_q),
    .dvd_o(dvd), .dvs_o(dvs), .mca_o(mca), .mcb_o(mcb),
    .q_neg_o(q_neg), .r_neg_o(r_neg), .p_neg_o(p_neg),
    .dvs_zero_o(dvs_zero), .long_o(long_op)
  );

  mdu_div_core #(.DW(DW)) u_div (
    .clk_i, .rst_ni,
    .load_i(state_q == ST_PREP), .step_i(state_q == ST_RUN),
    .dvd_i(dvd), .dvs_i(dvs), .quo_o(quo), .rem_o(rem)
  );

  mdu_mul_core #(.DW(DW)) u_mul (
    .clk_i, .rst_ni,
    .load_i(state_q == ST_PREP), .step_i(state_q == ST_RUN),
    .a_i(mca), .b_i(mcb), .prod_o(prod)
  );

  mdu_result_fix #(.DW(DW)) u_fix (
    .op_i(op_q), .quo_i(quo), .rem_i(rem), .prod_i(prod),
    .q_neg_i(q_neg), .r_neg_i(r_neg), .p_neg_i(p_neg), .dvs_zero_i(dvs_zero),
    .d_i(d_q), .x_i(x_q), .y_i(y_q), .flags_i(flags_q),
    .d_o(d_fix), .x_o(x_fix), .y_o(y_fix), .flags_o(flags_fix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_SDIV16;
      d_q     <= '0;
      x_q     <= '0;
      y_q     <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
      d_o     <= '0;
      x_o     <= '0;
      y_o     <= '0;
      flags_o <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          op_q    <= mdu_op_e'(op_i);
          d_q     <= d_i;
          x_q     <= x_i;
          y_q     <= y_i;
          flags_q <= flags_i;
          state_q <= ST_PREP;
        end
        ST_PREP: begin
          cnt_q   <= long_op ? CW'(QW) : CW'(DW);
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q - CW'(1);
          if (cnt_q == CW'(1)) state_q <= ST_FIN;
        end
        ST_FIN: begin
          d_o     <= d_fix;
          x_o     <= x_fix;
          y_o     <= y_fix;
          flags_o <= flags_fix;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/ext_muldiv_chk.sv
module ext_muldiv_chk import mdu_pkg::*; #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [1:0]    op_i,
  input logic [DW-1:0] d_i,
  input logic [DW-1:0] x_i,
  input logic [DW-1:0] y_i,
  input logic [3:0]    flags_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] d_o,
  input logic [DW-1:0] x_o,
  input logic [DW-1:0] y_o,
  input logic [3:0]    flags_o
);
  logic          acc;
  logic [1:0]    c_op;
  logic [DW-1:0] c_d, c_x, c_y;
  logic [3:0]    c_f;

  assign acc = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_op <= '0; c_d <= '0; c_x <= '0; c_y <= '0; c_f <= '0;
    end else if (acc) begin
      c_op <= op_i; c_d <= d_i; c_x <= x_i; c_y <= y_i; c_f <= flags_i;
    end
  end

  a_r9_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> busy_o);

  a_r10_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r11_outputs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(d_o) && $stable(x_o) && $stable(y_o) && $stable(flags_o)));

  a_r5_zero_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && c_op != 2'd3 && c_x == '0) |->
      (flags_o == (c_f | 4'b0001) && d_o == c_d && x_o == c_x && y_o == c_y));

  a_r6_carry_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && c_op != 2'd3 && c_x != '0) |-> !flags_o[FLG_C]);

  a_r8_mul_keeps_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && c_op == 2'd3) |-> (flags_o[FLG_V] == c_f[FLG_V] && x_o == c_x));
endmodule

bind ext_muldiv ext_muldiv_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
  .d_i(d_i), .x_i(x_i), .y_i(y_i), .flags_i(flags_i),
  .busy_o(busy_o), .done_o(done_o), .d_o(d_o), .x_o(x_o), .y_o(y_o),
  .flags_o(flags_o)
);

// File: tb/ext_muldiv_test.sv
`timescale 1ns/1ps
module ext_muldiv_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [15:0] d_i = '0, x_i = '0, y_i = '0;
  logic [3:0]  flags_i = '0;
  logic        busy_o, done_o;
  logic [15:0] d_o, x_o, y_o;
  logic [3:0]  flags_o;

  int total = 0;
  int bad = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk_i = ~clk_i;

  ext_muldiv uut (.*);

  initial begin
    repeat (190000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: run hung, got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] op, input logic [15:0] d, x, y, input logic [3:0] f,
                       output logic [15:0] ed, ex, ey, output logic [3:0] ef);
    longint a, b, q, r, p;
    ed = d; ex = x; ey = y; ef = f;
    if (op == 2'd3) begin
      p = longint'($signed(d)) * longint'($signed(y));
      ey = p[31:16]; ed = p[15:0];
      ef[2] = (p[31:0] == 0); ef[3] = p[31]; ef[0] = p[15];
    end else if (x == 0) begin
      ef[0] = 1'b1;
    end else begin
      if (op == 2'd0) begin a = longint'($signed(d)); b = longint'($signed(x)); end
      else if (op == 2'd1) begin a = longint'({32'h0, y, d}); b = longint'({48'h0, x}); end
      else begin a = longint'($signed({y, d})); b = longint'($signed(x)); end
      q = a / b; r = a % b;
      ed = r[15:0];
      if (op == 2'd0) ex = q[15:0]; else ey = q[15:0];
      ef[0] = 1'b0;
      ef[1] = (op == 2'd1) ? (q > 65535) : (q > 32767 || q < -32768);
      ef[2] = (q == 0);
      ef[3] = q[15];
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [15:0] d, x, y, input logic [3:0] f,
                        input bit disturb);
    logic [15:0] ed, ex, ey;
    logic [3:0]  ef;
    int n;
    string rt, ft;
    model(op, d, x, y, f, ed, ex, ey, ef);
    @(negedge clk_i);
    op_i = op; d_i = d; x_i = x; y_i = y; flags_i = f; start_i = 1'b1;
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
      start_i = 1'b0;
      if (n == 1) chk("R9 busy after start", 64'(busy_o), 64'd1);
      if (disturb && n == 5) begin
        start_i = 1'b1; op_i = ~op; d_i = ~d; x_i = 16'h0007; y_i = ~y; flags_i = ~f;
      end
    end while (!done_o && n < 100);
    start_i = 1'b0;
    if (x == 0 && op != 2'd3) begin rt = "R5 regs"; ft = "R5 flags"; end
    else if (op == 2'd3) begin rt = "R7 regs"; ft = "R8 flags"; end
    else begin
      rt = (op == 2'd0) ? "R2 regs" : (op == 2'd1) ? "R3 regs" : "R4 regs";
      ft = "R6 flags";
    end
    chk(rt, {16'h0, d_o, x_o, y_o}, {16'h0, ed, ex, ey});
    chk(ft, 64'(flags_o), 64'(ef));
    chk("R10 latency", 64'(n), (op == 2'd1 || op == 2'd2) ? 64'd35 : 64'd19);
    chk("R10 not busy at done", 64'(busy_o), 64'd0);
    @(negedge clk_i);
    chk("R10 done single pulse", 64'(done_o), 64'd0);
    if (disturb) chk("R9 busy start ignored", 64'(busy_o), 64'd0);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  initial begin
    logic [15:0] cv [8];
    logic [15:0] hd, hx, hy;
    logic [3:0]  hf;
    cv[0] = 16'h0000; cv[1] = 16'h0001; cv[2] = 16'hFFFF; cv[3] = 16'h7FFF;
    cv[4] = 16'h8000; cv[5] = 16'h0003; cv[6] = 16'hFFFD; cv[7] = 16'h1234;
    repeat (3) @(negedge clk_i);
    chk("R1 reset outputs", {busy_o, done_o, d_o, x_o, y_o, flags_o}, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", {busy_o, done_o, d_o, x_o, y_o, flags_o}, 64'h0);

    // corner sweep
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          if (op == 3) run_op(2'(op), cv[i], cv[(i + 3) % 8], cv[j], 4'(i + j), 1'b0);
          else         run_op(2'(op), cv[i], cv[j], cv[(i + j) % 8], 4'(i + j), 1'b0);
        end

    // directed overflow boundaries
    run_op(2'd0, 16'h8000, 16'hFFFF, 16'h5555, 4'h0, 1'b0);  // R2 R6
    run_op(2'd2, 16'h0000, 16'hFFFF, 16'h8000, 4'h0, 1'b0);  // R4 R6
    run_op(2'd2, 16'h8000, 16'h0001, 16'hFFFF, 4'h0, 1'b0);  // R4 exactly -32768
    run_op(2'd2, 16'h7FFF, 16'h0001, 16'h0000, 4'h0, 1'b0);  // R4 exactly 32767
    run_op(2'd2, 16'h8000, 16'h0001, 16'h0000, 4'h0, 1'b0);  // R4 32768
    run_op(2'd1, 16'hFFFF, 16'h1234, 16'h1233, 4'h0, 1'b0);  // R3 fits
    run_op(2'd1, 16'h0000, 16'h1234, 16'h1234, 4'h0, 1'b0);  // R3 overflows
    run_op(2'd3, 16'h8000, 16'h0000, 16'h8000, 4'h2, 1'b0);  // R7 R8
    run_op(2'd0, 16'hFFF9, 16'h0002, 16'h0000, 4'hF, 1'b0);  // R2 -7/2

    // start while busy (R9)
    for (int op = 0; op < 4; op++)
      run_op(2'(op), 16'hC123, 16'h0035, 16'h0012, 4'h6, 1'b1);

    // outputs hold across input changes (R11)
    hd = d_o; hx = x_o; hy = y_o; hf = flags_o;
    op_i = 2'd3; d_i = 16'hDEAD; x_i = 16'hBEEF; y_i = 16'h0F0F; flags_i = 4'hA;
    repeat (6) @(negedge clk_i);
    chk("R11 outputs hold", {12'h0, d_o, x_o, y_o, flags_o}, {12'h0, hd, hx, hy, hf});

    // pseudo-random sweep
    for (int k = 0; k < 800; k++) begin
      logic [15:0] rd, rx, ry;
      lfsr = nxt(lfsr); rd = lfsr[15:0]; rx = lfsr[31:16];
      lfsr = nxt(lfsr); ry = lfsr[15:0];
      if (k % 3 == 0) rx = {8'h0, rx[7:0]} | 16'h1;
      run_op(2'(k % 4), rd, rx, ry, lfsr[19:16], 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule